// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter with Cascade Strobes

This block is a small up/down counter whose direction is picked by which of two strobe lines moves. One of them pulses low and returns high while the other stays high. The count steps on the low-to-high return of the pulsing strobe. The counter also has an active-low parallel preset and an active-high clear. A parameter fixes the modulus: decade (0 to 9) or full binary (0 to 2^CNT_W-1).

The whole block runs on one fast system clock. The two strobes, the preset enable and the clear are taken as asynchronous levels and pass through two-flop synchronisers. A third sampling flop then finds rising edges on the strobes. The counter drives two active-low cascade strobes. The overflow strobe goes low while the count sits at its top value and the up strobe is low. The underflow strobe goes low while the count is zero and the down strobe is low. Each of these strobes rises on the same clock edge as the wrap it announces. A following stage can therefore take them directly as its up and down strobes, with no extra logic between stages.

Top module: `dual_strobe_counter`

## Requirements
- R1: While `rst` is high and on the first cycles after it, `count_o` is 0 and both `carry_n_o` and `borrow_n_o` are 1.
- R2: A rising transition on `up_stb_i` applied between clock edges raises the count by one on the third rising `clk` edge after it. The count does not change when the strobe falls or while it is held low.
- R3: An up step from the top value gives 0; the top value is 9 when DECADE=1 and 15 when DECADE=0. With DECADE=1, an up step from any value of 10 to 15 also gives 0.
- R4: A rising transition on `dn_stb_i` lowers the count by one, with the same latency as R2. A down step from 0 gives the top value, and with DECADE=1 a down step from any value of 10 to 15 gives that value minus one.
- R5: `carry_n_o` is 0 exactly when the count equals the top value and the synchronised, delayed up strobe is low. When the up strobe returns high from the top value, `carry_n_o` rises in the same cycle in which `count_o` becomes 0.
- R6: `borrow_n_o` is 0 exactly when the count is 0 and the delayed down strobe is low. When the down strobe returns high from 0, `borrow_n_o` rises in the same cycle in which `count_o` becomes the top value.
- R7: While `load_n_i` is low (after its two-cycle synchronisation), `count_o` follows `preset_i` unchanged for every value 0 to 15, and strobe edges have no effect.
- R8: While `clear_i` is high (after synchronisation), `count_o` is 0 regardless of `load_n_i`, `preset_i` and both strobes.
- R9: Rising transitions on both strobes that are detected in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| up_stb_i | input | 1 | Up-count strobe, idle high, asynchronous |
| dn_stb_i | input | 1 | Down-count strobe, idle high, asynchronous |
| load_n_i | input | 1 | Preset enable, active low, asynchronous |
| clear_i | input | 1 | Clear, active high, asynchronous |
| preset_i | input | CNT_W | Preset value, held stable while loading |
| count_o | output | CNT_W | Current count |
| carry_n_o | output | 1 | Active-low overflow cascade strobe |
| borrow_n_o | output | 1 | Active-low underflow cascade strobe |

## Verification
The hardest case to reach is the edge on which a cascade strobe rises: the count must wrap on that same edge, neither one cycle early nor one cycle late. The stimulus drives the counter to each wrap point, either by long strobe sweeps or by presetting the value directly. It holds the strobe low long enough for the cascade output to settle, and then releases it. The outputs are sampled on the second and on the third clock after the release, so a skew of one cycle between count and strobe shows up. Decade values of 10 to 15 can only be reached through the preset, so every value 0 to 15 is loaded and then stepped in both directions.

// File: rtl/dsc_pkg.sv
`timescale 1ns/1ps
package dsc_pkg;

    // Synchronised control levels, packed MSB first.
    typedef struct packed {
        logic up;
        logic dn;
        logic load_n;
        logic clear;
    } ctl_t;

    localparam int unsigned CTL_W = $bits(ctl_t);

    // Idle levels: strobes high, preset enable inactive, clear inactive.
    localparam ctl_t CTL_IDLE = '{up: 1'b1, dn: 1'b1, load_n: 1'b1, clear: 1'b0};

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_LOAD,
        ACT_UP,
        ACT_DN
    } act_e;

    function automatic int unsigned top_value(bit decade, int unsigned width);
        return decade ? 9 : ((1 << width) - 1);
    endfunction

endpackage

// File: rtl/dsc_sync.sv
`timescale 1ns/1ps
module dsc_sync #(
    parameter int unsigned N      = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= RST_VAL;
                    else     stage[g] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= RST_VAL;
                    else     stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/dsc_edge.sv
`timescale 1ns/1ps
module dsc_edge (
    input  logic clk,
    input  logic rst,
    input  logic up_s,
    input  logic dn_s,
    output logic up_d,
    output logic dn_d,
    output logic up_rise,
    output logic dn_rise
);
    always_ff @(posedge clk) begin
        if (rst) begin
            up_d <= 1'b1;
            dn_d <= 1'b1;
        end else begin
            up_d <= up_s;
            dn_d <= dn_s;
        end
    end

    assign up_rise = up_s & ~up_d;
    assign dn_rise = dn_s & ~dn_d;
endmodule

// File: rtl/dsc_core.sv
`timescale 1ns/1ps
module dsc_core #(
    parameter int unsigned CNT_W = 4,
    parameter logic [CNT_W-1:0] TOP = 4'd9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_s,
    input  logic             load_n_s,
    input  logic             up_rise,
    input  logic             dn_rise,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] count
);
    import dsc_pkg::*;

    act_e             act;
    logic [CNT_W-1:0] nxt;

    // Fixed priority: clear, then preset, then a single strobe edge.
    always_comb begin
        if (clear_s)                 act = ACT_CLEAR;
        else if (!load_n_s)          act = ACT_LOAD;
        else if (up_rise && !dn_rise) act = ACT_UP;
        else if (dn_rise && !up_rise) act = ACT_DN;
        else                         act = ACT_HOLD;
    end

    always_comb begin
        case (act)
            ACT_CLEAR: nxt = '0;
            ACT_LOAD:  nxt = preset;
            ACT_UP:    nxt = (count >= TOP) ? '0 : count + 1'b1;
            ACT_DN:    nxt = (count == '0) ? TOP : count - 1'b1;
            default:   nxt = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= nxt;
    end
endmodule

// File: rtl/dsc_cascade.sv
`timescale 1ns/1ps
module dsc_cascade #(
    parameter int unsigned CNT_W = 4,
    parameter logic [CNT_W-1:0] TOP = 4'd9
) (
    input  logic [CNT_W-1:0] count,
    input  logic             up_d,
    input  logic             dn_d,
    output logic             carry_n,
    output logic             borrow_n
);
    // The delayed strobe sample rises on the same edge that updates the count.
    assign carry_n  = ~((count == TOP) & ~up_d);
    assign borrow_n = ~((count == '0)  & ~dn_d);
endmodule

// File: rtl/dual_strobe_counter.sv
`timescale 1ns/1ps
module dual_strobe_counter #(
    parameter int unsigned CNT_W    = 4,
    parameter bit          DECADE   = 1'b1,
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_stb_i,
    input  logic             dn_stb_i,
    input  logic             load_n_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] preset_i,
    output logic [CNT_W-1:0] count_o,
    output logic             carry_n_o,
    output logic             borrow_n_o
);
    import dsc_pkg::*;

    localparam logic [CNT_W-1:0] TOP = CNT_W'(top_value(DECADE, CNT_W));

    logic [CTL_W-1:0] ctl_raw;
    logic [CTL_W-1:0] ctl_q;
    ctl_t             ctl;
    logic             up_d, dn_d, up_rise, dn_rise;

    assign ctl_raw = {up_stb_i, dn_stb_i, load_n_i, clear_i};
    assign ctl     = ctl_t'(ctl_q);

    dsc_sync #(
        .N      (CTL_W),
        .STAGES (SYNC_LEN),
        .RST_VAL(CTL_W'(CTL_IDLE))
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (ctl_raw),
        .q  (ctl_q)
    );

    dsc_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .up_s   (ctl.up),
        .dn_s   (ctl.dn),
        .up_d   (up_d),
        .dn_d   (dn_d),
        .up_rise(up_rise),
        .dn_rise(dn_rise)
    );

    dsc_core #(
        .CNT_W(CNT_W),
        .TOP  (TOP)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .clear_s (ctl.clear),
        .load_n_s(ctl.load_n),
        .up_rise (up_rise),
        .dn_rise (dn_rise),
        .preset  (preset_i),
        .count   (count_o)
    );

    dsc_cascade #(
        .CNT_W(CNT_W),
        .TOP  (TOP)
    ) u_cascade (
        .count   (count_o),
        .up_d    (up_d),
        .dn_d    (dn_d),
        .carry_n (carry_n_o),
        .borrow_n(borrow_n_o)
    );
endmodule

// File: rtl/dsc_checker.sv
`timescale 1ns/1ps
module dsc_checker #(
    parameter int unsigned CNT_W  = 4,
    parameter bit          DECADE = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             up_stb_i,
    input logic             dn_stb_i,
    input logic             load_n_i,
    input logic             clear_i,
    input logic [CNT_W-1:0] preset_i,
    input logic [CNT_W-1:0] count_o,
    input logic             carry_n_o,
    input logic             borrow_n_o
);
    localparam logic [CNT_W-1:0] MAXV = DECADE ? CNT_W'(9) : {CNT_W{1'b1}};

    logic [2:0] age;
    always_ff @(posedge clk) begin
        if (rst)             age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end

    logic [CNT_W-1:0] prev_cnt;
    logic             settled;
    always_ff @(posedge clk) prev_cnt <= count_o;
    assign settled = (age >= 3'd4);

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (count_o == '0 && carry_n_o && borrow_n_o)); // R1

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (settled && $past(clear_i, 3)) |-> (count_o == '0)); // R8

    AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (settled && !$past(clear_i, 3) && !$past(load_n_i, 3))
        |-> (count_o == $past(preset_i, 1))); // R7

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (settled && !$past(clear_i, 3) && $past(load_n_i, 3) && count_o != prev_cnt)
        |-> (count_o == ((prev_cnt >= MAXV) ? '0 : prev_cnt + 1'b1)
             || count_o == ((prev_cnt == '0) ? MAXV : prev_cnt - 1'b1))); // R3

    AST_CARRY_LOW: assert property (@(posedge clk) disable iff (rst)
        (settled && !carry_n_o) |-> (count_o == MAXV && !$past(up_stb_i, 3))); // R5

    AST_BORROW_LOW: assert property (@(posedge clk) disable iff (rst)
        (settled && !borrow_n_o) |-> (count_o == '0 && !$past(dn_stb_i, 3))); // R6
endmodule

bind dual_strobe_counter dsc_checker #(
    .CNT_W (CNT_W),
    .DECADE(DECADE)
) u_dsc_checker (
    .clk       (clk),
    .rst       (rst),
    .up_stb_i  (up_stb_i),
    .dn_stb_i  (dn_stb_i),
    .load_n_i  (load_n_i),
    .clear_i   (clear_i),
    .preset_i  (preset_i),
    .count_o   (count_o),
    .carry_n_o (carry_n_o),
    .borrow_n_o(borrow_n_o)
);

// File: tb/test_dual_strobe_counter.sv
`timescale 1ns/1ps
module test_dual_strobe_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       up = 1'b1, dn = 1'b1, load_n = 1'b1, clear = 1'b0;
    logic [3:0] preset = 4'd0;
    logic [3:0] cnt_d, cnt_b;
    logic       cy_d, cy_b, bw_d, bw_b;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int ed = 0;   // expected decade count
    int eb = 0;   // expected binary count

    always #5 clk = ~clk;

    dual_strobe_counter #(.CNT_W(4), .DECADE(1'b1)) i_dual_strobe_counter (
        .clk(clk), .rst(rst), .up_stb_i(up), .dn_stb_i(dn), .load_n_i(load_n),
        .clear_i(clear), .preset_i(preset), .count_o(cnt_d),
        .carry_n_o(cy_d), .borrow_n_o(bw_d));

    dual_strobe_counter #(.CNT_W(4), .DECADE(1'b0)) i_dual_strobe_counter_bin (
        .clk(clk), .rst(rst), .up_stb_i(up), .dn_stb_i(dn), .load_n_i(load_n),
        .clear_i(clear), .preset_i(preset), .count_o(cnt_b),
        .carry_n_o(cy_b), .borrow_n_o(bw_b));

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_counts(input string req);
        check({req, " decade count"}, int'(cnt_d), ed);
        check({req, " binary count"}, int'(cnt_b), eb);
    endtask

    function automatic int up_of(input int v, input int mx);
        return (v >= mx) ? 0 : v + 1;
    endfunction

    function automatic int dn_of(input int v, input int mx);
        return (v == 0) ? mx : v - 1;
    endfunction

    // R2 R3 R5: pulse up, check the cascade strobe and the wrap on the same edge
    task automatic pulse_up();
        up = 1'b0;
        step(4);
        check_counts("R2 hold while up low");
        check("R5 carry low decade", int'(cy_d), (ed == 9) ? 0 : 1);
        check("R5 carry low binary", int'(cy_b), (eb == 15) ? 0 : 1);
        up = 1'b1;
        step(2);
        check_counts("R2 no change before third edge");
        check("R5 carry before wrap decade", int'(cy_d), (ed == 9) ? 0 : 1);
        step(1);
        ed = up_of(ed, 9);
        eb = up_of(eb, 15);
        check_counts("R3 up step");
        check("R5 carry high with wrap decade", int'(cy_d), 1);
        check("R5 carry high with wrap binary", int'(cy_b), 1);
        step(1);
    endtask

    // R4 R6: pulse down
    task automatic pulse_dn();
        dn = 1'b0;
        step(4);
        check_counts("R4 hold while down low");
        check("R6 borrow low decade", int'(bw_d), (ed == 0) ? 0 : 1);
        check("R6 borrow low binary", int'(bw_b), (eb == 0) ? 0 : 1);
        dn = 1'b1;
        step(2);
        check_counts("R4 no change before third edge");
        check("R6 borrow before wrap binary", int'(bw_b), (eb == 0) ? 0 : 1);
        step(1);
        ed = dn_of(ed, 9);
        eb = dn_of(eb, 15);
        check_counts("R4 down step");
        check("R6 borrow high with wrap decade", int'(bw_d), 1);
        check("R6 borrow high with wrap binary", int'(bw_b), 1);
        step(1);
    endtask

    // R7: preset a value, with an up pulse during the load that must be ignored
    task automatic load_value(input int v);
        preset = v[3:0];
        load_n = 1'b0;
        step(4);
        ed = v;
        eb = v;
        check_counts("R7 preset copied");
        up = 1'b0;
        step(4);
        up = 1'b1;
        step(4);
        check_counts("R7 strobe ignored during load");
        load_n = 1'b1;
        step(4);
        check_counts("R7 value kept after load");
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        step(5);
        check_counts("R1 reset");
        check("R1 carry in reset", int'(cy_d), 1);
        check("R1 borrow in reset", int'(bw_b), 1);
        rst = 1'b0;
        step(4);
        check_counts("R1 after reset");

        // Up and down sweeps through both wraps.
        for (int i = 0; i < 18; i++) pulse_up();
        for (int i = 0; i < 18; i++) pulse_dn();

        // Every preset value stepped both ways (R3, R4 out-of-range decade values).
        for (int v = 0; v < 16; v++) begin
            load_value(v);
            pulse_up();
            load_value(v);
            pulse_dn();
        end

        // R8: clear overrides load, preset and strobes.
        load_value(5);
        clear = 1'b1;
        load_n = 1'b0;
        preset = 4'd7;
        step(4);
        ed = 0;
        eb = 0;
        check_counts("R8 clear beats load");
        up = 1'b0;
        step(4);
        up = 1'b1;
        step(4);
        dn = 1'b0;
        step(4);
        dn = 1'b1;
        step(4);
        check_counts("R8 clear beats strobes");
        load_n = 1'b1;
        step(2);
        clear = 1'b0;
        step(4);
        check_counts("R8 zero after clear");

        // R9: both strobes rise together.
        load_value(4);
        up = 1'b0;
        dn = 1'b0;
        step(4);
        up = 1'b1;
        dn = 1'b1;
        step(5);
        check_counts("R9 simultaneous edges hold");

        // R1: reset in mid-run.
        pulse_up();
        rst = 1'b1;
        step(2);
        ed = 0;
        eb = 0;
        check_counts("R1 mid-run reset");
        rst = 1'b0;
        step(4);
        pulse_dn();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule